// File: doc/BRIEF.md
# Hours-Minutes-Seconds Timekeeper with Scanned Six-Digit Display

This block keeps wall-clock time from a 32.768 kHz timebase. A free-running binary prescaler turns that timebase into a one-second event, and the seconds, minutes and hours are held as packed BCD pairs. Seconds and minutes run 00 to 59 and hours run 00 to 23, so 23:59:59 rolls over to 00:00:00. One of two timebase sources is chosen by a select pin: a local oscillator or an externally supplied clock. Every register in the block runs from the chosen source. A global reset clears all state at once, without waiting for a clock edge.

A mode pin switches the block between running and setting. While setting, the seconds pair is held at 00. Two push-button inputs each add one to the hours or to the minutes. Each button is synchronised and edge-detected, so one press gives one step however long the button is held. The current time is shown on six seven-segment digits through one shared active-high segment bus. The digits are scanned in turn, and one active-high enable per digit selects the digit being driven. The block also brings out a 1 Hz square wave for test, and one-cycle strobes at every minute rollover and every hour rollover. Oscillator circuitry, level shifting and display polarity inversion are handled outside the block.

Top module: `hms_timekeeper`

## Requirements
- R1: The seconds count advances by one once every 2^DIV_BITS cycles of the selected timebase while in running mode. The first advance after reset comes at the 2^DIV_BITS-th edge.
- R2: `sq1hz_o` is the top bit of the prescaler. After reset it is low for 2^(DIV_BITS-1) timebase cycles and then high for 2^(DIV_BITS-1) cycles, repeating. Each falling edge of `sq1hz_o` happens at the same edge as a seconds advance.
- R3: `min_stb_o` is high for one cycle, in the cycle that starts at the edge where seconds roll from 59 to 00. `hr_stb_o` is high in that same cycle only when minutes also roll from 59 to 00. Neither strobe fires in setting mode.
- R4: Seconds and minutes count 00..59 in BCD and hours count 00..23 in BCD. Seconds 59 carries into minutes, minutes 59 carries into hours, and 23:59:59 becomes 00:00:00.
- R5: With `src_sel_i` = 0 the block runs from `osc_clk_i`, and with `src_sel_i` = 1 it runs from `ext_clk_i`. Edges on the unselected source have no effect on any output.
- R6: Raising `rst_i` at once, with no clock edge, clears the time to 00:00:00, the prescaler and both strobes to 0, and the scan to the seconds-units digit. The outputs then read `dig_en_o` = 6'b000001 and `seg_o` = 7'h3F.
- R7: While `set_mode_i` = 1 the seconds pair is forced to 00 at every timebase edge, and the time does not advance.
- R8: In setting mode, a rising edge on `adv_min_i` adds one to the minutes and a rising edge on `adv_hr_i` adds one to the hours. Minutes wrap from 59 to 00 with no carry into hours, and hours wrap from 23 to 00. The new value is visible after the third timebase edge following the button's rise.
- R9: A button held high for many cycles produces exactly one step. Both buttons are ignored in running mode.
- R10: Exactly one bit of `dig_en_o` is high at any time. Bit 0 selects seconds units, bit 1 seconds tens, bit 2 minutes units, bit 3 minutes tens, bit 4 hours units and bit 5 hours tens. The active bit moves up by one position, wrapping from bit 5 to bit 0, at each edge where the low SCAN_BITS prescaler bits are all ones.
- R11: `seg_o` carries segment a in bit 0 through segment g in bit 6, active high. Digits 0..9 are shown as 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Timebase from the local oscillator |
| ext_clk_i | input | 1 | Externally supplied timebase |
| src_sel_i | input | 1 | Timebase choice: 0 local oscillator, 1 external |
| rst_i | input | 1 | Asynchronous global reset, active high |
| set_mode_i | input | 1 | 0 running, 1 setting |
| adv_hr_i | input | 1 | Hour advance button, active high |
| adv_min_i | input | 1 | Minute advance button, active high |
| seg_o | output | 7 | Shared segment bus, bit 0 = a … bit 6 = g |
| dig_en_o | output | 6 | One-hot digit enables |
| sq1hz_o | output | 1 | 1 Hz square wave for test |
| min_stb_o | output | 1 | One-cycle pulse at each minute rollover |
| hr_stb_o | output | 1 | One-cycle pulse at each hour rollover |

## Verification
The seconds advance, the fall of the test square wave and both strobes all come from the same timebase edge. Each strobe is therefore checked in the very cycle where the square wave is first seen low. The displayed time then holds for a full 2^DIV_BITS cycles, and the display scoreboard reads all six digits in the first dozen cycles after that fall, so a capture never straddles a seconds change. A button step lands three edges after the button rises, and the bench waits four cycles after each release before relying on it. Reset is checked one nanosecond after it rises, with no clock edge in between, and the scan position is checked at the second and fourth falling edges after reset is released.

// File: rtl/tk_pkg.sv
package tk_pkg;

  localparam int NUM_DIGITS = 6;
  localparam int NUM_BTN    = 2;
  localparam int BTN_MIN    = 0;
  localparam int BTN_HR     = 1;
  localparam int SEG_W      = 7;

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] ones;
  } bcd2_t;

  localparam bcd2_t BCD_ZERO   = '{tens: 4'd0, ones: 4'd0};
  localparam bcd2_t SIXTY_TOP  = '{tens: 4'd5, ones: 4'd9};
  localparam bcd2_t DAY_TOP    = '{tens: 4'd2, ones: 4'd3};

  // Next value of a BCD pair, wrapping to zero after the given top value.
  function automatic bcd2_t bcd2_step(bcd2_t v, bcd2_t top);
    bcd2_t r;
    if (v == top) begin
      r = BCD_ZERO;
    end else if (v.ones == 4'd9) begin
      r.tens = v.tens + 4'd1;
      r.ones = 4'd0;
    end else begin
      r.tens = v.tens;
      r.ones = v.ones + 4'd1;
    end
    return r;
  endfunction

  function automatic logic bcd2_at(bcd2_t v, bcd2_t top);
    return (v == top);
  endfunction

  // Segment pattern, bit 0 = a ... bit 6 = g, active high.
  function automatic logic [SEG_W-1:0] seg_pattern(logic [3:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int DIV_BITS  = 15,
  parameter int SCAN_BITS = 5
) (
  input  logic clk,
  input  logic rst,
  output logic sec_tick_o,
  output logic scan_tick_o,
  output logic sq_o
);

  logic [DIV_BITS-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // Full count: the edge that ends one second.
  assign sec_tick_o  = &cnt;
  // Low bits full: the edge that steps the display scan.
  assign scan_tick_o = &cnt[SCAN_BITS-1:0];
  assign sq_o        = cnt[DIV_BITS-1];

endmodule

// File: rtl/tk_btn_edge.sv
module tk_btn_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  output logic pulse_o
);

  logic [STAGES:0] shreg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], btn_i};
  end

  // Rising edge of the synchronised level, one cycle wide.
  assign pulse_o = shreg[STAGES-1] & ~shreg[STAGES];

endmodule

// File: rtl/tk_time_core.sv
module tk_time_core
  import tk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sec_tick_i,
  input  logic  set_mode_i,
  input  logic  adv_min_i,
  input  logic  adv_hr_i,
  output bcd2_t sec_o,
  output bcd2_t min_o,
  output bcd2_t hr_o,
  output logic  min_stb_o,
  output logic  hr_stb_o
);

  logic sec_full, min_full;
  assign sec_full = bcd2_at(sec_o, SIXTY_TOP);
  assign min_full = bcd2_at(min_o, SIXTY_TOP);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sec_o     <= BCD_ZERO;
      min_o     <= BCD_ZERO;
      hr_o      <= BCD_ZERO;
      min_stb_o <= 1'b0;
      hr_stb_o  <= 1'b0;
    end else begin
      min_stb_o <= 1'b0;
      hr_stb_o  <= 1'b0;
      if (set_mode_i) begin
        sec_o <= BCD_ZERO;
        if (adv_min_i) min_o <= bcd2_step(min_o, SIXTY_TOP);
        if (adv_hr_i)  hr_o  <= bcd2_step(hr_o, DAY_TOP);
      end else if (sec_tick_i) begin
        sec_o <= bcd2_step(sec_o, SIXTY_TOP);
        if (sec_full) begin
          min_o     <= bcd2_step(min_o, SIXTY_TOP);
          min_stb_o <= 1'b1;
          if (min_full) begin
            hr_o     <= bcd2_step(hr_o, DAY_TOP);
            hr_stb_o <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/tk_digit_scan.sv
module tk_digit_scan
  import tk_pkg::*;
#(
  parameter int N = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [N*4-1:0]   digits_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [N-1:0]     en_o
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] idx;
  logic [3:0]       dig_arr [N];
  logic [3:0]       cur_digit;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                idx <= '0;
    else if (step_i) begin
      if (idx == LAST)      idx <= '0;
      else                  idx <= idx + 1'b1;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_digit
    assign dig_arr[k] = digits_i[k*4 +: 4];
    assign en_o[k]    = (idx == IDX_W'(k));
  end

  always_comb begin
    cur_digit = 4'd0;
    for (int k = 0; k < N; k++) begin
      if (idx == IDX_W'(k)) cur_digit = dig_arr[k];
    end
  end

  assign seg_o = seg_pattern(cur_digit);

endmodule

// File: rtl/hms_timekeeper.sv
module hms_timekeeper
  import tk_pkg::*;
#(
  parameter int DIV_BITS    = 15,
  parameter int SCAN_BITS   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  osc_clk_i,
  input  logic                  ext_clk_i,
  input  logic                  src_sel_i,
  input  logic                  rst_i,
  input  logic                  set_mode_i,
  input  logic                  adv_hr_i,
  input  logic                  adv_min_i,
  output logic [SEG_W-1:0]      seg_o,
  output logic [NUM_DIGITS-1:0] dig_en_o,
  output logic                  sq1hz_o,
  output logic                  min_stb_o,
  output logic                  hr_stb_o
);

  // Selected timebase drives every register.
  logic tick_clk;
  assign tick_clk = src_sel_i ? ext_clk_i : osc_clk_i;

  logic sec_tick, scan_tick;

  tk_prescaler #(
    .DIV_BITS  (DIV_BITS),
    .SCAN_BITS (SCAN_BITS)
  ) u_div (
    .clk         (tick_clk),
    .rst         (rst_i),
    .sec_tick_o  (sec_tick),
    .scan_tick_o (scan_tick),
    .sq_o        (sq1hz_o)
  );

  logic [NUM_BTN-1:0] btn_raw, btn_pulse;
  assign btn_raw[BTN_MIN] = adv_min_i;
  assign btn_raw[BTN_HR]  = adv_hr_i;

  for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
    tk_btn_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (tick_clk),
      .rst     (rst_i),
      .btn_i   (btn_raw[g]),
      .pulse_o (btn_pulse[g])
    );
  end

  logic adv_min_pulse, adv_hr_pulse;
  assign adv_min_pulse = btn_pulse[BTN_MIN];
  assign adv_hr_pulse  = btn_pulse[BTN_HR];

  bcd2_t sec_bcd, min_bcd, hr_bcd;
  logic  min_stb, hr_stb;

  tk_time_core u_time (
    .clk        (tick_clk),
    .rst        (rst_i),
    .sec_tick_i (sec_tick),
    .set_mode_i (set_mode_i),
    .adv_min_i  (adv_min_pulse),
    .adv_hr_i   (adv_hr_pulse),
    .sec_o      (sec_bcd),
    .min_o      (min_bcd),
    .hr_o       (hr_bcd),
    .min_stb_o  (min_stb),
    .hr_stb_o   (hr_stb)
  );

  // Digit k of the bus feeds enable k: seconds units at the bottom.
  logic [NUM_DIGITS*4-1:0] digit_bus;
  assign digit_bus = {hr_bcd.tens, hr_bcd.ones,
                      min_bcd.tens, min_bcd.ones,
                      sec_bcd.tens, sec_bcd.ones};

  tk_digit_scan #(.N(NUM_DIGITS)) u_scan (
    .clk      (tick_clk),
    .rst      (rst_i),
    .step_i   (scan_tick),
    .digits_i (digit_bus),
    .seg_o    (seg_o),
    .en_o     (dig_en_o)
  );

  assign min_stb_o = min_stb;
  assign hr_stb_o  = hr_stb;

endmodule

// File: rtl/tk_checker.sv
module tk_checker
  import tk_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  set_mode,
  input logic                  sec_tick,
  input logic                  scan_tick,
  input bcd2_t                 sec_bcd,
  input bcd2_t                 min_bcd,
  input bcd2_t                 hr_bcd,
  input logic                  min_stb,
  input logic                  hr_stb,
  input logic [NUM_DIGITS-1:0] dig_en
);

  logic sec_ok, min_ok, hr_ok;
  assign sec_ok = (sec_bcd.tens <= 4'd5) && (sec_bcd.ones <= 4'd9);
  assign min_ok = (min_bcd.tens <= 4'd5) && (min_bcd.ones <= 4'd9);
  assign hr_ok  = (hr_bcd.tens < 4'd2) ? (hr_bcd.ones <= 4'd9)
                                       : ((hr_bcd.tens == 4'd2) && (hr_bcd.ones <= 4'd3));

  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (rst)
    sec_ok && min_ok && hr_ok); // R4

  AST_SET_SEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    set_mode |=> (sec_bcd == BCD_ZERO)); // R7

  AST_RUN_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (!set_mode && !sec_tick) |=> ($stable(min_bcd) && $stable(hr_bcd))); // R9

  AST_MIN_STB_AT_ROLL: assert property (@(posedge clk) disable iff (rst)
    min_stb |-> (sec_bcd == BCD_ZERO)); // R3

  AST_HR_STB_WITH_MIN: assert property (@(posedge clk) disable iff (rst)
    hr_stb |-> (min_stb && (min_bcd == BCD_ZERO))); // R3

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    min_stb |=> !min_stb); // R3

  AST_SCAN_ROTATE: assert property (@(posedge clk) disable iff (rst)
    scan_tick |=> (dig_en == {$past(dig_en[NUM_DIGITS-2:0]), $past(dig_en[NUM_DIGITS-1])})); // R10

  AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !scan_tick |=> $stable(dig_en)); // R10

  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $countones(dig_en) == 1); // R10

endmodule

bind hms_timekeeper tk_checker u_tk_checker (
  .clk       (tick_clk),
  .rst       (rst_i),
  .set_mode  (set_mode_i),
  .sec_tick  (sec_tick),
  .scan_tick (scan_tick),
  .sec_bcd   (sec_bcd),
  .min_bcd   (min_bcd),
  .hr_bcd    (hr_bcd),
  .min_stb   (min_stb),
  .hr_stb    (hr_stb),
  .dig_en    (dig_en_o)
);

// File: tb/tb_hms_timekeeper.sv
`timescale 1ns/1ps
module tb_hms_timekeeper;

  localparam int DIV  = 5;
  localparam int SCAN = 1;

  logic osc = 1'b0, ext = 1'b0, sel = 1'b0, rst = 1'b1, setm = 1'b0, ah = 1'b0, am = 1'b0;
  logic [6:0] seg;
  logic [5:0] en;
  logic sq, mstb, hstb;

  always #2.5 osc = ~osc;

  hms_timekeeper #(.DIV_BITS(DIV), .SCAN_BITS(SCAN), .SYNC_STAGES(2)) dut (
    .osc_clk_i (osc), .ext_clk_i (ext), .src_sel_i (sel), .rst_i (rst),
    .set_mode_i (setm), .adv_hr_i (ah), .adv_min_i (am),
    .seg_o (seg), .dig_en_o (en), .sq1hz_o (sq),
    .min_stb_o (mstb), .hr_stb_o (hstb)
  );

  int nrun = 0, nfail = 0;
  int falls = 0, min_cnt = 0, hr_cnt = 0;
  logic prev_sq = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nrun++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R11 decoding, restated from the requirement.
  function automatic int seg2dig(input logic [6:0] s);
    case (s)
      7'h3F: return 0;  7'h06: return 1;  7'h5B: return 2;  7'h4F: return 3;
      7'h66: return 4;  7'h6D: return 5;  7'h7D: return 6;  7'h07: return 7;
      7'h7F: return 8;  7'h6F: return 9;
      default: return 15;
    endcase
  endfunction

  // Edge and strobe monitor, sampled on the falling half of the clock.
  always @(negedge osc) begin
    if (rst) prev_sq <= 1'b0;
    else begin
      if (prev_sq && !sq) falls++;
      if (mstb) begin
        min_cnt++;
        chk("R3 minute strobe in the cycle of the test-output fall", int'(prev_sq && !sq), 1);
      end
      if (hstb) begin
        hr_cnt++;
        chk("R3 hour strobe together with minute strobe", int'(mstb), 1);
      end
      prev_sq <= sq;
    end
  end

  // Scoreboard of expected displayed times.
  typedef struct { string tag; int hh; int mm; int ss; } exp_t;
  exp_t sbq[$];

  initial begin : monitor
    int dig [6];
    bit seen [6];
    int nseen, prev_k, k, act, expv;
    bit bad_hot, bad_ord;
    exp_t e;
    forever begin
      @(negedge osc);
      if (sbq.size() > 0) begin
        for (int i = 0; i < 6; i++) begin dig[i] = 15; seen[i] = 0; end
        nseen = 0; prev_k = -1; bad_hot = 0; bad_ord = 0;
        for (int c = 0; c < 16 && nseen < 6; c++) begin
          if ($countones(en) != 1) bad_hot = 1;
          else begin
            k = 0;
            for (int i = 0; i < 6; i++) if (en[i]) k = i;
            if (prev_k >= 0 && k != prev_k && k != (prev_k + 1) % 6) bad_ord = 1;
            prev_k = k;
            if (!seen[k]) begin seen[k] = 1; nseen++; end
            dig[k] = seg2dig(seg);
          end
          if (nseen < 6) @(negedge osc);
        end
        e = sbq[0];
        act  = dig[5]*100000 + dig[4]*10000 + dig[3]*1000 + dig[2]*100 + dig[1]*10 + dig[0];
        expv = e.hh*10000 + e.mm*100 + e.ss;
        chk(e.tag, act, expv);
        chk("R10 exactly one enable during scan", int'(bad_hot), 0);
        chk("R10 enable order", int'(bad_ord), 0);
        void'(sbq.pop_front());
      end
    end
  end

  task automatic expect_time(input string tag, input int h, input int m, input int s);
    exp_t e;
    e.tag = tag; e.hh = h; e.mm = m; e.ss = s;
    sbq.push_back(e);
    while (sbq.size() != 0) @(negedge osc);
  endtask

  task automatic wait_falls(input int target);
    while (falls < target) begin @(negedge osc); #1; end
  endtask

  task automatic press(input bit hour, input int hold);
    @(negedge osc);
    if (hour) ah = 1'b1; else am = 1'b1;
    repeat (hold) @(negedge osc);
    ah = 1'b0; am = 1'b0;
    repeat (4) @(negedge osc);
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    nfail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin : driver
    int base, tog;
    logic sq0;
    logic [5:0] en0;
    logic last;

    // R6 reset state, with no clock edge needed
    #1;
    chk("R6 reset enables", int'(en), 1);
    chk("R6 reset segments", int'(seg), 'h3F);
    chk("R6 reset test output", int'(sq), 0);
    chk("R6 reset strobes", int'({mstb, hstb}), 0);
    repeat (3) @(negedge osc);
    rst = 1'b0;

    // R2 square wave phase, R10 scan step rate
    for (int n = 1; n <= 32; n++) begin
      @(negedge osc);
      if (n == 1)  chk("R10 scan at seconds units", int'(en), 1);
      if (n == 2)  chk("R10 first scan step", int'(en), 2);
      if (n == 4)  chk("R10 second scan step", int'(en), 4);
      if (n == 15) chk("R2 test output low half", int'(sq), 0);
      if (n == 16) chk("R2 test output rises", int'(sq), 1);
      if (n == 31) chk("R2 test output high half", int'(sq), 1);
      if (n == 32) chk("R2 test output falls", int'(sq), 0);
    end
    #1;
    chk("R2 fall count after first second", falls, 1);
    expect_time("R1 one second elapsed", 0, 0, 1);
    wait_falls(2);  expect_time("R1 two seconds", 0, 0, 2);
    wait_falls(3);  expect_time("R1 three seconds", 0, 0, 3);
    wait_falls(59); expect_time("R4 seconds at 59", 0, 0, 59);
    wait_falls(60); expect_time("R4 seconds carry into minutes", 0, 1, 0);
    chk("R3 one minute strobe", min_cnt, 1);
    chk("R3 no hour strobe yet", hr_cnt, 0);

    // Setting mode
    setm = 1'b1;
    repeat (2) @(negedge osc);
    expect_time("R7 seconds forced to zero", 0, 1, 0);
    press(0, 20);
    expect_time("R9 long press gives one step", 0, 2, 0);
    repeat (2) press(0, 3);
    expect_time("R8 minute advance", 0, 4, 0);
    repeat (2) press(1, 3);
    expect_time("R8 hour advance", 2, 4, 0);
    repeat (21) press(1, 3);
    expect_time("R8 hours at 23", 23, 4, 0);
    press(1, 3);
    expect_time("R8 hours wrap 23 to 00", 0, 4, 0);
    repeat (23) press(1, 3);
    repeat (55) press(0, 3);
    expect_time("R8 minutes at 59", 23, 59, 0);
    press(0, 3);
    expect_time("R8 minute wrap without hour carry", 23, 0, 0);
    repeat (59) press(0, 3);
    expect_time("R7 set mode holds seconds at zero", 23, 59, 0);
    chk("R3 no minute strobe in setting mode", min_cnt, 1);
    chk("R3 no hour strobe in setting mode", hr_cnt, 0);

    // Running again: buttons ignored, day rollover
    @(negedge osc);
    setm = 1'b0;
    base = falls;
    wait_falls(base + 1);
    press(0, 3);
    press(1, 3);
    wait_falls(base + 2);
    expect_time("R9 buttons ignored while running", 23, 59, 2);
    wait_falls(base + 60);
    expect_time("R4 23:59:59 rolls to 00:00:00", 0, 0, 0);
    chk("R3 hour strobe at rollover", hr_cnt, 1);
    chk("R3 minute strobe count at rollover", min_cnt, 2);

    // R5 source select
    @(negedge osc);
    sel = 1'b1;
    sq0 = sq; en0 = en;
    repeat (100) @(negedge osc);
    chk("R5 unselected oscillator has no effect on test output", int'(sq), int'(sq0));
    chk("R5 unselected oscillator has no effect on scan", int'(en), int'(en0));
    tog = 0; last = sq;
    repeat (64) begin
      #3 ext = 1'b1;
      #3 ext = 1'b0;
      if (sq != last) tog++;
      last = sq;
    end
    chk("R5 R1 external source drives the prescaler", tog, 4);
    @(negedge osc);
    sel = 1'b0;

    // R6 asynchronous reset mid-run
    repeat (20) @(negedge osc);
    @(posedge osc);
    #1 rst = 1'b1;
    #1;
    chk("R6 async reset enables", int'(en), 1);
    chk("R6 async reset segments", int'(seg), 'h3F);
    chk("R6 async reset test output", int'(sq), 0);
    chk("R6 async reset strobes", int'({mstb, hstb}), 0);
    @(negedge osc);
    rst = 1'b0;
    expect_time("R6 time cleared by reset", 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

endmodule